// File: doc/BRIEF.md
# Display PHY Bring-up Sequencer

This block brings a four-lane serial display PHY out of power-down. It is driven by a register-held control word, a channel power word and three wait values. From these it produces the lane power-up enables and the lane release signals. It also passes through the clock-path enables and reports two status flags. The flags say when the analog bias has settled and when the escape-clock domain has been synchronised. Everything except the escape-clock handshake runs on the lane byte clock.

The PHY counts as on while the clock-lane power-down bit and the global soft reset are both clear. From that point the block steps through three waits: an analog-up wait, a bias-settle wait and an initialisation wait. Lanes are released only after all three have run. Any global reset, or powering down the clock lane, sends the sequence straight back to off.

Software asks for escape-clock synchronisation by setting a control bit. A toggle handshake crosses into the escape domain and back, and the ready flag rises once the handshake is complete.

Top module: `dphy_bringup_seq`

## Requirements
- R1: While `rst_n` is low, and after its release with the PHY held off, `status`, `ana_pwr_up`, `clk_release` and `lane_release` are all zero.
- R2: `clk_pwr_up` is 1 exactly when `chan_word[4]` and `ctrl_word[31]` are both 0. `lane_pwr_up[i]` is additionally gated by `chan_word[i]` (a 1 powers lane i down). The words 0x0E, 0x0C, 0x08 and 0x00 therefore power lanes {0}, {0,1}, {0,1,2} and all four.
- R3: Let edge 1 be the first byte-clock edge that sees the PHY on. Bias ready (`status[0]`) is first high after edge A+B+3, where A is `anaup_wait` and B is `bias_wait`. `ana_pwr_up` is high from edge 1.
- R4: The clock lane and the powered lanes are first released after edge A+B+T+4, where T is `init_wait`. No release is ever high while bias ready is low.
- R5: Once the sequence has completed, `ctrl_word[30]` holds the clock lane unreleased. `ctrl_word[26+i]` (bits 29..26 for lanes 3..0) holds data lane i unreleased. Both act at once.
- R6: Setting `ctrl_word[31]` or `chan_word[4]` clears bias ready, `ana_pwr_up` and all releases after the next byte-clock edge. The power-up outputs drop at once.
- R7: A 0-to-1 change of `ctrl_word[1]` clears escape ready (`status[1]`) after the next edge. Escape ready then rises within 40 byte clocks, provided the escape clock is no slower than a third of the byte clock.
- R8: Escape ready is cleared by `ctrl_word[31]` or `chan_word[4]`. It does not return without a new 0-to-1 change of `ctrl_word[1]`.
- R9: `clk_enables` reflects control bits {12, 9, 8, 7, 0} as bits [4:0]: byte clock, divider output, divider counter, PLL clock, transmit DDR clock.
- R10: With all three waits at zero, bias ready follows edge 3 and release follows edge 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| byte_clk | input | 1 | Lane byte clock |
| rst_n | input | 1 | Active-low reset, byte domain |
| esc_clk | input | 1 | Escape clock |
| esc_rst_n | input | 1 | Active-low reset, escape domain |
| ctrl_word | input | 32 | Control word: soft resets, clock enables, sync request |
| chan_word | input | NUM_LANES+1 | Per-lane power-down bits, top bit is clock lane / whole PHY |
| anaup_wait | input | CNT_W | Analog-up wait in byte clocks |
| bias_wait | input | CNT_W | Bias-settle wait in byte clocks |
| init_wait | input | CNT_W | Initialisation wait in byte clocks |
| ana_pwr_up | output | 1 | Power-up request to the analog section |
| clk_pwr_up | output | 1 | Clock-lane power-up |
| clk_release | output | 1 | Clock-lane reset release |
| lane_pwr_up | output | NUM_LANES | Data-lane power-up |
| lane_release | output | NUM_LANES | Data-lane reset release |
| clk_enables | output | 5 | Clock-path enables |
| status | output | 2 | {escape ready, bias ready} |

## Verification
The bench measures the exact edge count to bias ready and to release for non-zero waits and for all-zero waits. A design that lost or gained a cycle in any phase, or that skipped a phase when its count was zero, would report the wrong count. It drives every lane-count power word and several lane-reset combinations, which catches a reversed lane order or a clock-lane reset wired to a data lane. For escape synchronisation it checks three things: ready drops on the request edge, ready rises afterwards, and a global reset clears ready without letting it come back. A design that compared the handshake against stale toggle state would show ready again with no new request.

// File: rtl/dphy_seq_pkg.sv
package dphy_seq_pkg;

  typedef enum logic [2:0] {
    PH_OFF  = 3'd0,
    PH_ANA  = 3'd1,
    PH_BIAS = 3'd2,
    PH_INIT = 3'd3,
    PH_RUN  = 3'd4
  } phase_t;

  // Countdown step: saturates at zero.
  function automatic logic [31:0] step_down(input logic [31:0] cnt);
    return (cnt == 32'd0) ? 32'd0 : cnt - 32'd1;
  endfunction

  // A phase loaded with count w occupies w+1 byte-clock edges.
  function automatic int unsigned phase_edges(input int unsigned w);
    return w + 1;
  endfunction

endpackage

// File: rtl/dphy_wait_seq.sv
module dphy_wait_seq
  import dphy_seq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             phy_off,
  input  logic [CNT_W-1:0] anaup_wait,
  input  logic [CNT_W-1:0] bias_wait,
  input  logic [CNT_W-1:0] init_wait,
  output logic             ana_pwr_up,
  output logic             bias_ready,
  output logic             seq_done
);

  phase_t           phase;
  logic [CNT_W-1:0] cnt;
  logic             cnt_zero;
  logic [31:0]      cnt_next;

  assign cnt_zero = (cnt == '0);
  assign cnt_next = step_down(32'(cnt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_OFF;
      cnt   <= '0;
    end else if (phy_off) begin
      phase <= PH_OFF;
      cnt   <= '0;
    end else begin
      unique case (phase)
        PH_OFF: begin
          phase <= PH_ANA;
          cnt   <= anaup_wait;
        end
        PH_ANA: begin
          if (cnt_zero) begin
            phase <= PH_BIAS;
            cnt   <= bias_wait;
          end else begin
            cnt <= cnt_next[CNT_W-1:0];
          end
        end
        PH_BIAS: begin
          if (cnt_zero) begin
            phase <= PH_INIT;
            cnt   <= init_wait;
          end else begin
            cnt <= cnt_next[CNT_W-1:0];
          end
        end
        PH_INIT: begin
          if (cnt_zero) phase <= PH_RUN;
          else          cnt   <= cnt_next[CNT_W-1:0];
        end
        default: phase <= PH_RUN;
      endcase
    end
  end

  assign ana_pwr_up = (phase != PH_OFF);
  assign bias_ready = (phase == PH_INIT) || (phase == PH_RUN);
  assign seq_done   = (phase == PH_RUN);

  // R6: an off request empties the sequence on the next edge
  assert_off_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    phy_off |=> (!bias_ready && !ana_pwr_up));

  // R3: bias ready only ever appears while the analog section was requested
  assert_bias_after_power_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bias_ready) |-> $past(ana_pwr_up));

endmodule

// File: rtl/dphy_lane_ctrl.sv
module dphy_lane_ctrl #(
  parameter int NUM_LANES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 phy_on,
  input  logic                 seq_done,
  input  logic                 bias_ready,
  input  logic [NUM_LANES-1:0] lane_pd,
  input  logic [NUM_LANES-1:0] lane_rst,
  input  logic                 clk_lane_rst,
  output logic                 clk_pwr_up,
  output logic                 clk_release,
  output logic [NUM_LANES-1:0] lane_pwr_up,
  output logic [NUM_LANES-1:0] lane_release
);

  assign clk_pwr_up  = phy_on;
  assign clk_release = phy_on && seq_done && !clk_lane_rst;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    assign lane_pwr_up[g]  = phy_on && !lane_pd[g];
    assign lane_release[g] = lane_pwr_up[g] && seq_done && !lane_rst[g];

    // R2: a lane is never released while it is powered down
    assert_release_powered_R2: assert property (@(posedge clk) disable iff (!rst_n)
      lane_release[g] |-> lane_pwr_up[g]);
  end

  // R4: nothing leaves reset before the bias has settled
  assert_release_needs_bias_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_release || (|lane_release)) |-> bias_ready);

endmodule

// File: rtl/dphy_esc_sync.sv
module dphy_esc_sync (
  input  logic byte_clk,
  input  logic rst_n,
  input  logic esc_clk,
  input  logic esc_rst_n,
  input  logic sync_bit,
  input  logic soft_rst,
  output logic esc_ready
);

  logic sync_q, req_tgl, pending, ack_s1, ack_s2;
  logic req_s1, req_s2, ack_tgl;
  logic trig, ack_match;

  assign trig      = sync_bit && !sync_q;
  assign ack_match = (ack_s2 == req_tgl);

  always_ff @(posedge byte_clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q    <= 1'b0;
      req_tgl   <= 1'b0;
      pending   <= 1'b0;
      esc_ready <= 1'b0;
      ack_s1    <= 1'b0;
      ack_s2    <= 1'b0;
    end else begin
      sync_q <= sync_bit;
      ack_s1 <= ack_tgl;
      ack_s2 <= ack_s1;
      if (trig) begin
        req_tgl   <= !req_tgl;
        pending   <= 1'b1;
        esc_ready <= 1'b0;
      end else if (soft_rst) begin
        esc_ready <= 1'b0;
      end else if (pending && ack_match) begin
        pending   <= 1'b0;
        esc_ready <= 1'b1;
      end
    end
  end

  always_ff @(posedge esc_clk or negedge esc_rst_n) begin
    if (!esc_rst_n) begin
      req_s1  <= 1'b0;
      req_s2  <= 1'b0;
      ack_tgl <= 1'b0;
    end else begin
      req_s1  <= req_tgl;
      req_s2  <= req_s1;
      ack_tgl <= req_s2;
    end
  end

  // R8: any reset condition drops escape ready
  assert_ready_clears_R8: assert property (@(posedge byte_clk) disable iff (!rst_n)
    soft_rst |=> !esc_ready);

  // R7: a new request always withdraws a previous ready
  assert_request_clears_R7: assert property (@(posedge byte_clk) disable iff (!rst_n)
    trig |=> !esc_ready);

endmodule

// File: rtl/dphy_bringup_seq.sv
module dphy_bringup_seq #(
  parameter int NUM_LANES = 4,
  parameter int CNT_W     = 16
) (
  input  logic                 byte_clk,
  input  logic                 rst_n,
  input  logic                 esc_clk,
  input  logic                 esc_rst_n,
  input  logic [31:0]          ctrl_word,
  input  logic [NUM_LANES:0]   chan_word,
  input  logic [CNT_W-1:0]     anaup_wait,
  input  logic [CNT_W-1:0]     bias_wait,
  input  logic [CNT_W-1:0]     init_wait,
  output logic                 ana_pwr_up,
  output logic                 clk_pwr_up,
  output logic                 clk_release,
  output logic [NUM_LANES-1:0] lane_pwr_up,
  output logic [NUM_LANES-1:0] lane_release,
  output logic [4:0]           clk_enables,
  output logic [1:0]           status
);

  localparam int GLB_RST_BIT  = 31;
  localparam int CLK_RST_BIT  = 30;
  localparam int LANE_RST_LSB = 26;
  localparam int SYNC_BIT     = 1;
  localparam int CLK_PD_BIT   = NUM_LANES;

  logic phy_off, phy_on, bias_ready, seq_done, esc_ready;
  logic unused_ctrl;

  assign phy_off = chan_word[CLK_PD_BIT] || ctrl_word[GLB_RST_BIT];
  assign phy_on  = !phy_off;

  assign clk_enables = {ctrl_word[12], ctrl_word[9], ctrl_word[8],
                        ctrl_word[7], ctrl_word[0]};
  assign unused_ctrl = ^{ctrl_word[25:13], ctrl_word[11:10], ctrl_word[6:2]};

  dphy_wait_seq #(.CNT_W(CNT_W)) u_seq (
    .clk        (byte_clk),
    .rst_n      (rst_n),
    .phy_off    (phy_off),
    .anaup_wait (anaup_wait),
    .bias_wait  (bias_wait),
    .init_wait  (init_wait),
    .ana_pwr_up (ana_pwr_up),
    .bias_ready (bias_ready),
    .seq_done   (seq_done)
  );

  dphy_lane_ctrl #(.NUM_LANES(NUM_LANES)) u_lanes (
    .clk          (byte_clk),
    .rst_n        (rst_n),
    .phy_on       (phy_on),
    .seq_done     (seq_done),
    .bias_ready   (bias_ready),
    .lane_pd      (chan_word[NUM_LANES-1:0]),
    .lane_rst     (ctrl_word[LANE_RST_LSB +: NUM_LANES]),
    .clk_lane_rst (ctrl_word[CLK_RST_BIT]),
    .clk_pwr_up   (clk_pwr_up),
    .clk_release  (clk_release),
    .lane_pwr_up  (lane_pwr_up),
    .lane_release (lane_release)
  );

  dphy_esc_sync u_esc (
    .byte_clk  (byte_clk),
    .rst_n     (rst_n),
    .esc_clk   (esc_clk),
    .esc_rst_n (esc_rst_n),
    .sync_bit  (ctrl_word[SYNC_BIT]),
    .soft_rst  (phy_off),
    .esc_ready (esc_ready)
  );

  assign status = {esc_ready, bias_ready};

endmodule

// File: tb/tb_dphy_bringup_seq.sv
module tb_dphy_bringup_seq;

  logic        clk = 1'b0, esc_clk = 1'b0;
  logic        rst_n = 1'b0, esc_rst_n = 1'b0;
  logic [31:0] ctrl_word = '0;
  logic [4:0]  chan_word = 5'h1F;
  logic [15:0] anaup_wait = '0, bias_wait = '0, init_wait = '0;
  logic        ana_pwr_up, clk_pwr_up, clk_release;
  logic [3:0]  lane_pwr_up, lane_release;
  logic [4:0]  clk_enables;
  logic [1:0]  status;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;
  always #30 esc_clk = ~esc_clk;

  dphy_bringup_seq dut (
    .byte_clk(clk), .rst_n(rst_n), .esc_clk(esc_clk), .esc_rst_n(esc_rst_n),
    .ctrl_word(ctrl_word), .chan_word(chan_word),
    .anaup_wait(anaup_wait), .bias_wait(bias_wait), .init_wait(init_wait),
    .ana_pwr_up(ana_pwr_up), .clk_pwr_up(clk_pwr_up), .clk_release(clk_release),
    .lane_pwr_up(lane_pwr_up), .lane_release(lane_release),
    .clk_enables(clk_enables), .status(status)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // Power the PHY from off and count edges to bias ready and to clock release.
  task automatic start_and_measure(input int a, input int b, input int t,
                                   output int n_bias, output int n_rel);
    chan_word = 5'h1F;
    repeat (2) @(negedge clk);
    anaup_wait = 16'(a); bias_wait = 16'(b); init_wait = 16'(t);
    chan_word = 5'h00;
    n_bias = 0; n_rel = 0;
    for (int n = 1; n < 2000; n++) begin
      @(posedge clk); @(negedge clk);
      if (n_bias == 0 && status[0]) n_bias = n;
      if (clk_release) begin n_rel = n; break; end
    end
  endtask

  task automatic t_reset();
    chk("R1 status in reset", 32'(status), 0);
    chk("R1 release in reset", 32'({clk_release, lane_release}), 0);
    @(negedge clk); rst_n = 1'b1; esc_rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 status after reset", 32'(status), 0);
    chk("R1 analog request held off", 32'(ana_pwr_up), 0);
    chk("R1 releases after reset", 32'({clk_release, lane_release}), 0);
  endtask

  task automatic t_masks();
    logic [4:0] words [4] = '{5'h0E, 5'h0C, 5'h08, 5'h00};
    for (int k = 0; k < 4; k++) begin
      chan_word = words[k]; #1;
      chk("R2 lane power for lane count", 32'(lane_pwr_up), 32'((1 << (k + 1)) - 1));
      chk("R2 clock lane powered", 32'(clk_pwr_up), 1);
    end
    chan_word = 5'h10; #1;
    chk("R2 whole phy down", 32'({clk_pwr_up, lane_pwr_up}), 0);
    chan_word = 5'h00; ctrl_word[31] = 1'b1; #1;
    chk("R2 global reset powers down", 32'({clk_pwr_up, lane_pwr_up}), 0);
    ctrl_word[31] = 1'b0; chan_word = 5'h1F;
    @(negedge clk);
  endtask

  task automatic t_timing();
    int nb, nr;
    start_and_measure(3, 5, 7, nb, nr);
    chk("R3 edges to bias ready", 32'(nb), 3 + 5 + 3);
    chk("R4 edges to release", 32'(nr), 3 + 5 + 7 + 4);
    chk("R4 all powered lanes released", 32'(lane_release), 32'hF);
    start_and_measure(0, 0, 0, nb, nr);
    chk("R10 zero waits bias ready", 32'(nb), 3);
    chk("R10 zero waits release", 32'(nr), 4);
  endtask

  task automatic t_lane_resets();
    chan_word = 5'h00;
    ctrl_word[27] = 1'b1; ctrl_word[30] = 1'b1; #1;
    chk("R5 lane1 held in reset", 32'(lane_release), 32'hD);
    chk("R5 clock lane held in reset", 32'(clk_release), 0);
    ctrl_word[27] = 1'b0; ctrl_word[30] = 1'b0; ctrl_word[29] = 1'b1;
    chan_word = 5'h0C; #1;
    chk("R5 two lanes, lane3 reset irrelevant", 32'(lane_release), 32'h3);
    ctrl_word[26] = 1'b1; #1;
    chk("R5 lane0 held in reset", 32'(lane_release), 32'h2);
    ctrl_word[29] = 1'b0; ctrl_word[26] = 1'b0; chan_word = 5'h00;
    @(negedge clk);
  endtask

  task automatic t_esc_sync();
    int seen;
    ctrl_word[1] = 1'b1;
    @(negedge clk);
    chk("R7 ready low after request", 32'(status[1]), 0);
    seen = 0;
    for (int n = 0; n < 40; n++) begin
      @(negedge clk);
      if (status[1]) begin seen = 1; break; end
    end
    chk("R7 escape ready rises", 32'(seen), 1);
    ctrl_word[31] = 1'b1;
    @(negedge clk);
    chk("R6 bias ready cleared", 32'(status[0]), 0);
    chk("R6 releases and analog request cleared",
        32'({ana_pwr_up, clk_release, lane_release}), 0);
    chk("R8 escape ready cleared by reset", 32'(status[1]), 0);
    ctrl_word[31] = 1'b0;
    repeat (40) @(negedge clk);
    chk("R8 ready stays low without new request", 32'(status[1]), 0);
    ctrl_word[1] = 1'b0; @(negedge clk);
    ctrl_word[1] = 1'b1;
    repeat (40) @(negedge clk);
    chk("R7 second request completes", 32'(status[1]), 1);
    chan_word = 5'h10;
    @(negedge clk);
    chk("R8 clock-lane power-down clears ready", 32'(status[1]), 0);
    ctrl_word[1] = 1'b0;
  endtask

  task automatic t_clk_en();
    ctrl_word = 32'h0000_1101; #1;
    chk("R9 enables bits 0,8,12", 32'(clk_enables), 32'h15);
    ctrl_word = 32'h0000_0280; #1;
    chk("R9 enables bits 7,9", 32'(clk_enables), 32'h0A);
    ctrl_word = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_masks();
    t_timing();
    t_lane_resets();
    t_esc_sync();
    t_clk_en();
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
    summary();
    $finish;
  end

endmodule